// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the word address for a synchronous burst memory. On a rising clock edge a start strobe can load a full address from the external bus. After that, the two least significant address bits are stepped inside their aligned four-word block, one step on each edge where the advance input is high. The upper bits keep the value that was loaded. An order-select input picks the stepping pattern. Linear order adds the step count to the loaded low bits, modulo four. Interleaved order XORs the step count with the loaded low bits.

There are two start strobes. The processor-side strobe loads only while chip enable is high. If it arrives while chip enable is low, it deselects the sequencer. The controller-side strobe loads whatever chip enable is doing, but only when the processor-side strobe is low. A small state machine tracks whether a burst is live, and advance pulses have an effect only while one is live. Loads may be issued on every cycle, so the block also works as a plain registered address path.

The state machine has two states. `ST_IDLE` is entered at reset and on a deselect. `ST_BURST` is entered on any load. Its transitions are:
- **load**: any state to `ST_BURST`.
- **deselect**: any state to `ST_IDLE`.
- **step**: `ST_BURST` to `ST_BURST`.
- **hold**: any state to itself.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is low, `addr_o` is all zeros and the sequencer is idle.
- R2: When `strobe_cpu_i` and `ce_i` are both high at a rising edge, `addr_o` equals the sampled `addr_i` after that edge.
- R3: When `strobe_cpu_i` is high and `ce_i` is low at an edge, nothing is loaded and `addr_o` keeps its value. The sequencer turns idle, so later advance pulses have no effect until the next load.
- R4: When `strobe_ctl_i` is high and `strobe_cpu_i` is low, `addr_i` is loaded whatever the level of `ce_i`.
- R5: `strobe_ctl_i` has no effect at an edge where `strobe_cpu_i` is high.
- R6: With `order_i` low (linear order), each advance during a burst moves the low two bits of `addr_o` to (loaded low bits + step count) modulo 4. For example, a start of 1 gives 1, 2, 3, 0.
- R7: With `order_i` high (interleaved order), the low two bits of `addr_o` equal (loaded low bits XOR step count). For example, a start of 1 gives 1, 0, 3, 2.
- R8: The upper address bits never change during a burst. After the fourth address, the next advance wraps back to the loaded word inside the same four-word block.
- R9: A load takes priority over `adv_i`. A load with advance also high yields the loaded address unchanged.
- R10: During a burst, an edge with no strobe and no advance leaves `addr_o` unchanged.
- R11: Loads on consecutive edges each take effect, one new address per cycle.
- R12: While the sequencer is idle, `adv_i` has no effect on `addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | External address bus |
| strobe_cpu_i | input | 1 | Processor-side burst start, qualified by `ce_i` |
| strobe_ctl_i | input | 1 | Controller-side burst start, unqualified |
| adv_i | input | 1 | Advance the burst by one word |
| ce_i | input | 1 | Chip enable, qualifies `strobe_cpu_i` |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Current internal word address |

## Verification
The assertions run on every cycle. They check the following:
- each qualified load shows the sampled bus address one cycle later;
- a deselect, or a controller strobe that collides with the processor strobe, leaves the address unchanged;
- the upper bits hold whenever there is no load;
- an advance during a burst always moves the low bits;
- advance pulses do nothing while the sequencer is idle.

The bench's scenarios drive full bursts in both orders. Only those scenarios can show the exact sequence values, wrap-around after four words, the load-over-advance priority and back-to-back loads.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } bseq_state_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_STEP  = 2'd2,
        ACT_DESEL = 2'd3
    } bseq_act_e;

endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import bseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strobe_cpu_i,
    input  logic        strobe_ctl_i,
    input  logic        ce_i,
    input  logic        adv_i,
    output bseq_act_e   act_o,
    output bseq_state_e state_o
);

    bseq_state_e state_q;
    bseq_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Action and next-state decode; strobes outrank advance,
    // the processor strobe outranks the controller strobe
    always_comb begin
        act_o   = ACT_HOLD;
        state_d = state_q;
        if (strobe_cpu_i && ce_i) begin
            act_o   = ACT_LOAD;
            state_d = ST_BURST;
        end else if (strobe_cpu_i) begin
            act_o   = ACT_DESEL;
            state_d = ST_IDLE;
        end else if (strobe_ctl_i) begin
            act_o   = ACT_LOAD;
            state_d = ST_BURST;
        end else begin
            unique case (state_q)
                ST_IDLE:  act_o = ACT_HOLD;
                ST_BURST: act_o = adv_i ? ACT_STEP : ACT_HOLD;
                default:  act_o = ACT_HOLD;
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/bseq_step.sv
module bseq_step
    import bseq_pkg::*;
#(
    parameter int BURST_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  bseq_act_e          act_i,
    output logic [BURST_W-1:0] step_o
);

    logic [BURST_W-1:0] step_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (act_i == ACT_LOAD) begin
            step_q <= '0;
        end else if (act_i == ACT_STEP) begin
            step_q <= step_q + 1'b1;
        end
    end

    assign step_o = step_q;

endmodule

// File: rtl/bseq_order.sv
module bseq_order #(
    parameter int BURST_W = 2
) (
    input  logic [BURST_W-1:0] base_i,
    input  logic [BURST_W-1:0] step_i,
    input  logic               order_i,
    output logic [BURST_W-1:0] low_o
);

    logic [BURST_W-1:0] lin_w;
    logic [BURST_W-1:0] ilv_w;

    assign lin_w = base_i + step_i;

    for (genvar b = 0; b < BURST_W; b++) begin : g_ilv
        assign ilv_w[b] = base_i[b] ^ step_i[b];
    end

    assign low_o = order_i ? ilv_w : lin_w;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              strobe_cpu_i,
    input  logic              strobe_ctl_i,
    input  logic              adv_i,
    input  logic              ce_i,
    input  logic              order_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int HI_W = ADDR_W - BURST_W;

    bseq_act_e          act_w;
    bseq_state_e        state_w;
    logic [BURST_W-1:0] step_w;
    logic [BURST_W-1:0] low_w;
    logic [HI_W-1:0]    hi_q;
    logic [BURST_W-1:0] base_q;
    logic               burst_act;

    bseq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_cpu_i (strobe_cpu_i),
        .strobe_ctl_i (strobe_ctl_i),
        .ce_i         (ce_i),
        .adv_i        (adv_i),
        .act_o        (act_w),
        .state_o      (state_w)
    );

    bseq_step #(.BURST_W(BURST_W)) u_step (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_i  (act_w),
        .step_o (step_w)
    );

    // Loaded address: upper bits and start word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            base_q <= '0;
        end else if (act_w == ACT_LOAD) begin
            hi_q   <= addr_i[ADDR_W-1:BURST_W];
            base_q <= addr_i[BURST_W-1:0];
        end
    end

    bseq_order #(.BURST_W(BURST_W)) u_order (
        .base_i  (base_q),
        .step_i  (step_w),
        .order_i (order_i),
        .low_o   (low_w)
    );

    assign burst_act = (state_w == ST_BURST);
    assign addr_o    = {hi_q, low_w};

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
    parameter int ADDR_W  = 20,
    parameter int BURST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              strobe_cpu_i,
    input logic              strobe_ctl_i,
    input logic              adv_i,
    input logic              ce_i,
    input logic              order_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              burst_act
);

    // R2: qualified processor load appears on the next cycle
    a_r2_cpu_load: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_cpu_i && ce_i) |=>
            (!$stable(order_i) || addr_o == $past(addr_i)));

    // R4: controller load regardless of chip enable
    a_r4_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_cpu_i && strobe_ctl_i) |=>
            (!$stable(order_i) || addr_o == $past(addr_i)));

    // R3: deselect turns the sequencer idle
    a_r3_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_cpu_i && !ce_i) |=> !burst_act);

    // R3 / R5: deselect, with or without controller strobe, keeps the address
    a_r5_ctl_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_cpu_i && !ce_i) |=> (!$stable(order_i) || $stable(addr_o)));

    // R8: upper bits only change on a load
    a_r8_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(strobe_cpu_i && ce_i) && (strobe_cpu_i || !strobe_ctl_i)) |=>
            $stable(addr_o[ADDR_W-1:BURST_W]));

    // R6 / R7: an advance in a burst always moves the low bits
    a_r6_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_act && adv_i && !strobe_cpu_i && !strobe_ctl_i) |=>
            (!$stable(order_i) || addr_o[BURST_W-1:0] != $past(addr_o[BURST_W-1:0])));

    // R10: idle cycle in a burst holds
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_act && !adv_i && !strobe_cpu_i && !strobe_ctl_i) |=>
            (!$stable(order_i) || $stable(addr_o)));

    // R12: advance does nothing while idle
    a_r12_idle_adv: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_act && !strobe_cpu_i && !strobe_ctl_i) |=>
            (!$stable(order_i) || $stable(addr_o)));

endmodule

bind burst_addr_seq bseq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_i       (addr_i),
    .strobe_cpu_i (strobe_cpu_i),
    .strobe_ctl_i (strobe_ctl_i),
    .adv_i        (adv_i),
    .ce_i         (ce_i),
    .order_i      (order_i),
    .addr_o       (addr_o),
    .burst_act    (burst_act)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          strobe_cpu_i = 1'b0;
    logic          strobe_ctl_i = 1'b0;
    logic          adv_i = 1'b0;
    logic          ce_i = 1'b0;
    logic          order_i = 1'b0;
    logic [AW-1:0] addr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [AW-1:0] val;
        string         tag;
    } exp_t;

    exp_t exp_q[$];

    // reference model state
    logic [AW-3:0] m_hi = '0;
    logic [1:0]    m_base = '0;
    logic [1:0]    m_step = '0;
    bit            m_act = 1'b0;

    always #5 clk = ~clk;

    burst_addr_seq uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_i       (addr_i),
        .strobe_cpu_i (strobe_cpu_i),
        .strobe_ctl_i (strobe_ctl_i),
        .adv_i        (adv_i),
        .ce_i         (ce_i),
        .order_i      (order_i),
        .addr_o       (addr_o)
    );

    function automatic logic [AW-1:0] model_addr(bit ord);
        logic [1:0] lo;
        lo = ord ? (m_base ^ m_step) : (m_base + m_step);
        return {m_hi, lo};
    endfunction

    task automatic drive(bit cpu, bit ctl, bit ce, bit adv, bit ord,
                         logic [AW-1:0] a, string tag);
        exp_t e;
        @(negedge clk);
        strobe_cpu_i = cpu;
        strobe_ctl_i = ctl;
        ce_i         = ce;
        adv_i        = adv;
        order_i      = ord;
        addr_i       = a;
        if (cpu && ce) begin
            m_hi = a[AW-1:2]; m_base = a[1:0]; m_step = '0; m_act = 1'b1;
        end else if (cpu) begin
            m_act = 1'b0;
        end else if (ctl) begin
            m_hi = a[AW-1:2]; m_base = a[1:0]; m_step = '0; m_act = 1'b1;
        end else if (adv && m_act) begin
            m_step = m_step + 2'd1;
        end
        e.val = model_addr(ord);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (addr_o !== e.val) begin
                    fails++;
                    $display("FAIL %s: addr_o=%h expected=%h", e.tag, addr_o, e.val);
                end
            end
        end
    end

    // watchdog
    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (addr_o !== '0) begin
            fails++;
            $display("FAIL R1: addr_o=%h expected=%h", addr_o, {AW{1'b0}});
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R12: advance before any load does nothing
        drive(0, 0, 0, 1, 0, 20'h55555, "R12 idle advance");
        drive(0, 0, 1, 1, 0, 20'h55555, "R12 idle advance ce");

        // R2 load, R6 linear 1,2,3,0, R8 wrap, R10 hold
        drive(1, 0, 1, 0, 0, 20'h12345, "R2 cpu load");
        drive(0, 0, 0, 1, 0, 20'hFFFFF, "R6 linear step1");
        drive(0, 0, 0, 1, 0, 20'h00000, "R6 linear step2");
        drive(0, 0, 0, 1, 0, 20'hFFFFF, "R6 linear step3");
        drive(0, 0, 0, 1, 0, 20'h00000, "R8 wrap to start");
        drive(0, 0, 0, 0, 0, 20'hABCDE, "R10 hold");
        drive(0, 0, 1, 0, 0, 20'hABCDE, "R10 hold ce");

        // R4 controller load with ce low, R7 interleaved 1,0,3,2
        drive(0, 1, 0, 0, 1, 20'hABCD5, "R4 ctl load");
        drive(0, 0, 0, 1, 1, 20'h0, "R7 interleave step1");
        drive(0, 0, 0, 1, 1, 20'h0, "R7 interleave step2");
        drive(0, 0, 0, 1, 1, 20'h0, "R7 interleave step3");
        drive(0, 0, 0, 1, 1, 20'h0, "R8 interleave wrap");

        // R9 load over advance
        drive(1, 0, 1, 1, 0, 20'h3C3C2, "R9 load beats advance");
        drive(0, 0, 0, 1, 0, 20'h0, "R9 first step after load");
        drive(0, 1, 1, 1, 1, 20'h77773, "R9 ctl load beats advance");

        // R3 / R5 deselect with ctl strobe, then advance ignored
        drive(1, 1, 0, 0, 1, 20'h11110, "R5 ctl ignored under cpu");
        drive(0, 0, 0, 1, 1, 20'h0, "R3 advance after deselect");
        drive(1, 0, 0, 1, 0, 20'h22222, "R3 deselect holds");
        drive(0, 1, 0, 0, 0, 20'h4444E, "R4 reload after deselect");
        drive(0, 0, 0, 1, 0, 20'h0, "R6 linear from 2");

        // R11 back-to-back loads
        for (int i = 0; i < 6; i++) begin
            drive(i[0], ~i[0], 1, 1, i[1], 20'h80001 + 20'(i * 5), "R11 back-to-back");
        end
        drive(0, 0, 0, 1, 1, 20'h0, "R11 step after last load");

        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule